// File: doc/BRIEF.md
# SDRAM Command-Mode Issue Controller

This block sits in front of an SDRAM device. Software uses it to choose the command that is sent when the host touches the memory window. A small register file holds the command mode, a mode-register selector for low-power parts and a write-lock bit. In normal mode every host access is forwarded, one cycle later, to a plain downstream read/write request port. In any other mode each host access, whether a read or a write, becomes a single forced command on the command bus. This lets software walk the device through its power-up sequence by hand: NOP, precharge of all banks, mode loads, refresh and low-power mode-register writes.

A mode written by software is held as pending. It only governs accesses from the next host write onward, and that write already uses it. Host reads that come before such a write keep the earlier behaviour. The block also tracks whether a precharge of all banks has happened since the last normal access. A refresh forced without one is still issued, but it raises a sticky sequencing-error flag.

Top module: `sdram_cmd_mode_ctrl`

## Requirements
- R1: After reset the mode, selector and lock bit are zero, no request or command is driven, and the sequencing-error flag is low.
- R2: Register offset 0 reads as {16'b0, selector[7:0], 3'b0, init_busy, 1'b0, mode[2:0]}. A write there updates the mode from bits 2:0 and the selector from bits 15:8, and ignores all other bits. Bit 4 follows the init_busy pin. Reads return data only while reg_rd is high and zero otherwise.
- R3: Offset 4 bit 0 is the write lock and reads back there. While it is 1, writes to offset 0 leave the mode and the selector unchanged.
- R4: A newly written mode applies to a host write access, which itself issues in the new mode. Host reads before that write use the mode that was active before.
- R5: In mode 0 a host access gives mem_req high one cycle later, with mem_we and mem_addr equal to the access. No command is issued.
- R6: In modes 1 to 7 any host access, read or write, gives exactly one cmd_valid pulse one cycle later and no mem_req. Command codes are given as {cs,ras,cas,we}: mode 1 gives NOP 0111 with bank and address 0, and mode 4 gives refresh 0001 with bank and address 0.
- R7: Mode 2 issues precharge 0010 with address bit 10 set, all other address bits 0 and bank 0.
- R8: The host address is {bank[2:0], row[12:0]}. Mode 3 issues load-mode 0000 with bank 0 and address equal to the row. Mode 5 issues 0000 with bank and address both taken from the host address.
- R9: Mode 7 issues 0000 with bank 0 and address equal to the 8-bit selector, zero-extended.
- R10: A refresh issued when no precharge-all has occurred since reset or since the last normal-mode access sets seq_err. The flag stays set until reset, and the refresh is still issued.
- R11: Mode 6 issues 0110 with address bit 10 set and bank 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read enable |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| init_busy | input | 1 | Device auto-initialization in progress |
| host_req | input | 1 | Host memory-window access |
| host_we | input | 1 | Host access is a write |
| host_addr | input | 16 | Host address {bank, row} |
| mem_req | output | 1 | Downstream normal request |
| mem_we | output | 1 | Downstream request is a write |
| mem_addr | output | 16 | Downstream request address |
| cmd_valid | output | 1 | Forced command strobe |
| cmd_code | output | 4 | Command {cs,ras,cas,we} |
| cmd_bank | output | 3 | Command bank |
| cmd_addr | output | 13 | Command address |
| seq_err | output | 1 | Sticky refresh-ordering error |

## Verification
The hardest case is the gap between a mode write and the access that makes it active. A host read made in that gap must still follow the old mode, and the next host write must already use the new one. The stimulus writes a new mode, reads the window, then writes it, and compares every cycle against a reference model. The refresh-ordering flag is reached in two steps. First a precharge and a refresh are issued without error. Then a normal access clears the precharge history, so that a second refresh trips the sticky flag.

// File: rtl/sdram_cmd_mode_ctrl.sv
module sdram_cmd_mode_ctrl #(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 13,
  parameter int RA_W   = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_wr,
  input  logic                      reg_rd,
  input  logic [RA_W-1:0]           reg_addr,
  input  logic [31:0]               reg_wdata,
  output logic [31:0]               reg_rdata,
  input  logic                      init_busy,
  input  logic                      host_req,
  input  logic                      host_we,
  input  logic [BANK_W+ROW_W-1:0]   host_addr,
  output logic                      mem_req,
  output logic                      mem_we,
  output logic [BANK_W+ROW_W-1:0]   mem_addr,
  output logic                      cmd_valid,
  output logic [3:0]                cmd_code,
  output logic [BANK_W-1:0]         cmd_bank,
  output logic [ROW_W-1:0]          cmd_addr,
  output logic                      seq_err
);
  localparam int HA_W = BANK_W + ROW_W;
  localparam logic [ROW_W-1:0] A10 = ROW_W'(1) << 10;
  localparam logic [RA_W-1:0] OFF_MODE = '0;
  localparam logic [RA_W-1:0] OFF_LOCK = RA_W'(4);

  logic [2:0] mode_q, act_q;
  logic [7:0] sel_q;
  logic       lock_q, pre_ok_q;

  wire [2:0]        use_mode = host_we ? mode_q : act_q;
  wire [BANK_W-1:0] h_bank   = host_addr[HA_W-1:ROW_W];
  wire [ROW_W-1:0]  h_row    = host_addr[ROW_W-1:0];
  wire              wr_mode  = reg_wr && reg_addr == OFF_MODE && !lock_q;

  logic unused_wbits;
  assign unused_wbits = ^{reg_wdata[31:16], reg_wdata[7:3]};

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if (reg_addr == OFF_MODE)      reg_rdata = {16'b0, sel_q, 3'b0, init_busy, 1'b0, mode_q};
      else if (reg_addr == OFF_LOCK) reg_rdata = {31'b0, lock_q};
    end
  end

  logic [3:0]        n_code;
  logic [BANK_W-1:0] n_bank;
  logic [ROW_W-1:0]  n_addr;
  always_comb begin
    n_code = 4'b0111;
    n_bank = '0;
    n_addr = '0;
    case (use_mode)
      3'd2: begin n_code = 4'b0010; n_addr = A10; end
      3'd3: begin n_code = 4'b0000; n_addr = h_row; end
      3'd4: n_code = 4'b0001;
      3'd5: begin n_code = 4'b0000; n_bank = h_bank; n_addr = h_row; end
      3'd6: begin n_code = 4'b0110; n_addr = A10; end
      3'd7: begin n_code = 4'b0000; n_addr = ROW_W'(sel_q); end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0; act_q <= '0; sel_q <= '0; lock_q <= 1'b0;
      pre_ok_q <= 1'b0; seq_err <= 1'b0;
      mem_req <= 1'b0; mem_we <= 1'b0; mem_addr <= '0;
      cmd_valid <= 1'b0; cmd_code <= '0; cmd_bank <= '0; cmd_addr <= '0;
    end else begin
      if (wr_mode) begin
        mode_q <= reg_wdata[2:0];
        sel_q  <= reg_wdata[15:8];
      end
      if (reg_wr && reg_addr == OFF_LOCK) lock_q <= reg_wdata[0];
      if (host_req && host_we) act_q <= mode_q;

      mem_req   <= host_req && use_mode == 3'd0;
      mem_we    <= host_req && use_mode == 3'd0 && host_we;
      mem_addr  <= (host_req && use_mode == 3'd0) ? host_addr : '0;
      cmd_valid <= host_req && use_mode != 3'd0;
      cmd_code  <= (host_req && use_mode != 3'd0) ? n_code : 4'b0;
      cmd_bank  <= (host_req && use_mode != 3'd0) ? n_bank : '0;
      cmd_addr  <= (host_req && use_mode != 3'd0) ? n_addr : '0;

      if (host_req) begin
        if (use_mode == 3'd0) pre_ok_q <= 1'b0;
        if (use_mode == 3'd2) pre_ok_q <= 1'b1;
        if (use_mode == 3'd4 && !pre_ok_q) seq_err <= 1'b1;
      end
    end
  end

  assert_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && mem_req));
  assert_cmd_from_host_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(host_req));
  assert_mem_from_host_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> $past(host_req));
  assert_lock_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFF_MODE && lock_q) |=> ($stable(mode_q) && $stable(sel_q)));
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> seq_err);
  assert_prech_a10_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 4'b0010) |-> cmd_addr[10]);
endmodule

// File: tb/tb_sdram_cmd_mode_ctrl.sv
module tb_sdram_cmd_mode_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0, init_busy = 0, host_req = 0, host_we = 0;
  logic [3:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [15:0] host_addr = 0, mem_addr;
  logic mem_req, mem_we, cmd_valid, seq_err;
  logic [3:0] cmd_code;
  logic [2:0] cmd_bank;
  logic [12:0] cmd_addr;

  sdram_cmd_mode_ctrl dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;
  string tag = "R1";
  int m_mode = 0, m_sel = 0, m_lock = 0, m_act = 0, m_pre = 0, m_err = 0;

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic step(input bit rw, input bit rr, input logic [3:0] ra, input logic [31:0] wd,
                      input bit hq, input bit hw, input logic [15:0] ha);
    int sel;
    logic [3:0] e_code; logic [2:0] e_bank; logic [12:0] e_addr;
    bit e_cv, e_mr;
    reg_wr = rw; reg_rd = rr; reg_addr = ra; reg_wdata = wd;
    host_req = hq; host_we = hw; host_addr = ha;
    #1;
    if (rr) begin
      if (ra == 0) chk({tag, " rdata"}, reg_rdata, {16'b0, 8'(m_sel), 3'b0, init_busy, 1'b0, 3'(m_mode)});
      else if (ra == 4) chk({tag, " rdata"}, reg_rdata, 32'(m_lock));
      else chk({tag, " rdata"}, reg_rdata, 0);
    end else chk({tag, " rdata idle"}, reg_rdata, 0);
    sel = hw ? m_mode : m_act;
    e_cv = hq && sel != 0; e_mr = hq && sel == 0;
    e_code = 0; e_bank = 0; e_addr = 0;
    if (e_cv) case (sel)
      1: e_code = 4'b0111;
      2: begin e_code = 4'b0010; e_addr = 13'd1024; end
      3: begin e_code = 4'b0000; e_addr = ha[12:0]; end
      4: e_code = 4'b0001;
      5: begin e_code = 4'b0000; e_bank = ha[15:13]; e_addr = ha[12:0]; end
      6: begin e_code = 4'b0110; e_addr = 13'd1024; end
      default: begin e_code = 4'b0000; e_addr = 13'(m_sel); end
    endcase
    if (hq) begin
      if (sel == 0) m_pre = 0;
      if (sel == 2) m_pre = 1;
      if (sel == 4 && m_pre == 0) m_err = 1;
      if (hw) m_act = m_mode;
    end
    if (rw && ra == 0 && m_lock == 0) begin m_mode = wd[2:0]; m_sel = wd[15:8]; end
    if (rw && ra == 4) m_lock = wd[0];
    @(posedge clk); @(negedge clk);
    chk({tag, " cmd_valid"}, cmd_valid, e_cv);
    chk({tag, " cmd_code"}, cmd_code, e_code);
    chk({tag, " cmd_bank"}, cmd_bank, e_bank);
    chk({tag, " cmd_addr"}, cmd_addr, e_addr);
    chk({tag, " mem_req"}, mem_req, e_mr);
    chk({tag, " mem_we"}, mem_we, e_mr && hw);
    chk({tag, " mem_addr"}, mem_addr, e_mr ? ha : 16'h0);
    chk({tag, " seq_err"}, seq_err, m_err);
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0, 0, 0); endtask
  task automatic wreg(input logic [3:0] a, input logic [31:0] d); step(1, 0, a, d, 0, 0, 0); endtask
  task automatic rreg(input logic [3:0] a); step(0, 1, a, 0, 0, 0, 0); endtask
  task automatic host(input bit w, input logic [15:0] a); step(0, 0, 0, 0, 1, w, a); endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    tag = "R1";
    chk("R1 cmd_valid", cmd_valid, 0); chk("R1 mem_req", mem_req, 0); chk("R1 seq_err", seq_err, 0);
    rreg(0); rreg(4); idle();
    tag = "R5"; host(1, 16'hA5C3); host(0, 16'h1234);
    tag = "R2"; init_busy = 1; wreg(0, 32'hFFFF_FFFF); rreg(0); init_busy = 0; rreg(0); rreg(8);
    tag = "R4"; host(0, 16'h0042); host(0, 16'h0043);
    tag = "R9"; host(1, 16'hFFFF);
    tag = "R6"; host(0, 16'h0001);
    tag = "R3"; wreg(4, 1); rreg(4); wreg(0, 32'h0000_3302); rreg(0); host(0, 16'h0);
    wreg(4, 0); wreg(0, 32'h0000_0002); rreg(0);
    tag = "R7"; host(1, 16'hFFFF); host(0, 16'h1111);
    tag = "R10"; wreg(0, 4); host(1, 16'h2222); idle();
    tag = "R5"; wreg(0, 0); host(1, 16'h7777); host(0, 16'h0100);
    tag = "R10"; wreg(0, 4); host(1, 16'h0); host(0, 16'h0); idle();
    tag = "R8"; wreg(0, 3); host(1, {3'd5, 13'h1234}); wreg(0, 5); host(1, {3'd5, 13'h1234}); host(0, {3'd2, 13'h0ABC});
    tag = "R6"; wreg(0, 1); host(1, 16'hFFFF); host(0, 16'h8000); idle(); host(0, 16'h0);
    tag = "R11"; wreg(0, 6); host(1, 16'hFFFF);
    tag = "R9"; wreg(0, 32'h0000_5A07); host(1, 16'h0); rreg(0);
    tag = "R10"; chk("R10 seq_err sticky", seq_err, 1);
    tag = "R1"; rst_n = 0; @(posedge clk); @(negedge clk); rst_n = 1;
    m_mode = 0; m_sel = 0; m_lock = 0; m_act = 0; m_pre = 0; m_err = 0;
    chk("R1 seq_err after reset", seq_err, 0); rreg(0); host(0, 16'h0F0F);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule